// File: doc/BRIEF.md
# Display Window Command Sequencer

This block turns a single rectangular screen-update request into the byte sequence that sets up an external display controller. The controller is reached over an 8-bit bus. Each beat on that bus is either a command byte or a data byte, and moves under a valid/ready handshake. A request carries an origin (x, y), a size (width, height), a 2-bit colour-mode code and three flag bits. Flag bit 0 asks for pixel doubling.

For a valid request, the block first programs three format registers, but only when the format has changed. It then sends the window rectangle as one command followed by a burst of eight data bytes. A one-cycle pulse then tells the downstream pixel mover that it may start. The block remembers the colour mode and flags of the last valid request, so repeated updates in the same format cost nine bus beats instead of fifteen. It also exports the bits per pixel of the accepted mode, so that a frame-buffer offset can be worked out downstream.

Top module: `win_cmd_seq`

## Requirements
- R1: A register write is one command beat carrying the register address, followed by one data beat. The format writes go to address 0x2A (input mode), then 0x2E (translation), then 0x36 (window type).
- R2: The window is sent as a command beat 0x38 followed by eight data beats in this order: x start, y start, x end, y end. Each coordinate is sent low byte first.
- R3: The x end sent is x+width-1 and the y end sent is y+height-1, both taken modulo 2^16.
- R4: Mode code 0 (RGB565) writes input mode 0x01 and translation 0x05. Code 1 (YUV422) writes 0x08 and 0x25. Code 2 (YUV420) writes 0x09 and 0x25.
- R5: Mode code 3 is rejected. The block raises `err` for one cycle, in the cycle after acceptance. It puts no beat on the bus, and the remembered format is left unchanged.
- R6: The three format writes happen only when the mode or the flags differ from those of the last accepted valid request. The first valid request after reset always writes them.
- R7: The window-type data byte is WT_INIT[7:2] in bits [7:2], 0 in bit 1, and flag bit 0 in bit 0.
- R8: `req_ready` is high exactly when no sequence is in progress, including directly after reset. A valid request starts its first bus beat in the cycle after acceptance.
- R9: While `bus_valid` is high and `bus_ready` is low, `bus_data` and `bus_is_cmd` hold their values.
- R10: `xfer_start` is high for exactly the one cycle that follows the handshake of the last window data byte.
- R11: From the cycle after a valid request is accepted, `bpp` reads 16 for RGB565 and YUV422, and 12 for YUV420.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_x | input | 16 | Window left column |
| req_y | input | 16 | Window top row |
| req_w | input | 16 | Window width in pixels |
| req_h | input | 16 | Window height in lines |
| req_mode | input | 2 | Colour mode code (0 RGB565, 1 YUV422, 2 YUV420, 3 invalid) |
| req_flags | input | 3 | Format flags, bit 0 = pixel doubling |
| bus_valid | output | 1 | Bus beat present |
| bus_ready | input | 1 | Bus takes the beat |
| bus_is_cmd | output | 1 | Beat is a command (1) or data (0) |
| bus_data | output | 8 | Beat byte |
| xfer_start | output | 1 | Pixel transfer may begin |
| err | output | 1 | Request rejected |
| bpp | output | 5 | Bits per pixel of last valid request |

## Verification
The end-of-sequence pulse and the acceptance of the next request can fall in the same cycle. This is because `req_ready` is already high in the cycle where `xfer_start` is raised. The bench provokes this by holding some requests valid throughout the previous sequence, so acceptance lands on the pulse cycle. It then judges the next request's first beat in the cycle after, along with whether that request correctly skips or repeats the format writes. A rejected request that follows a valid one, with a same-format request after it, checks that an error neither disturbs the bus nor changes the remembered format.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    localparam int COORD_W   = 16;
    localparam int BYTE_W    = 8;
    localparam int FLAG_W    = 3;
    localparam int BPP_W     = 5;
    localparam int NUM_STEPS = 15;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int FMT_BEATS = 6;
    localparam logic [STEP_W-1:0] WIN_STEP  = STEP_W'(FMT_BEATS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    localparam logic [BYTE_W-1:0] ADR_INMODE = 8'h2A;
    localparam logic [BYTE_W-1:0] ADR_TRANSL = 8'h2E;
    localparam logic [BYTE_W-1:0] ADR_WTYPE  = 8'h36;
    localparam logic [BYTE_W-1:0] ADR_WINDOW = 8'h38;

    typedef enum logic [1:0] {
        CM_RGB565 = 2'd0,
        CM_YUV422 = 2'd1,
        CM_YUV420 = 2'd2,
        CM_BAD    = 2'd3
    } cmode_e;

    typedef struct packed {
        logic              ok;
        logic [BYTE_W-1:0] conv;
        logic [BYTE_W-1:0] transl;
        logic [BPP_W-1:0]  bpp;
    } fmt_t;

    typedef struct packed {
        logic [COORD_W-1:0] xs;
        logic [COORD_W-1:0] ys;
        logic [COORD_W-1:0] xe;
        logic [COORD_W-1:0] ye;
        logic [BYTE_W-1:0]  conv;
        logic [BYTE_W-1:0]  transl;
        logic [BYTE_W-1:0]  wtype;
    } job_t;

    typedef struct packed {
        logic              is_cmd;
        logic [BYTE_W-1:0] data;
    } beat_t;

    function automatic logic [COORD_W-1:0] last_coord(input logic [COORD_W-1:0] org,
                                                      input logic [COORD_W-1:0] len);
        return org + len - COORD_W'(1);
    endfunction

endpackage

// File: rtl/win_fmt_decode.sv
module win_fmt_decode
    import wcs_pkg::*;
(
    input  cmode_e mode,
    output fmt_t   fmt
);
    always_comb begin
        unique case (mode)
            CM_RGB565: fmt = '{ok: 1'b1, conv: 8'h01, transl: 8'h05, bpp: 5'd16};
            CM_YUV422: fmt = '{ok: 1'b1, conv: 8'h08, transl: 8'h25, bpp: 5'd16};
            CM_YUV420: fmt = '{ok: 1'b1, conv: 8'h09, transl: 8'h25, bpp: 5'd12};
            default:   fmt = '{ok: 1'b0, conv: '0,    transl: '0,    bpp: '0};
        endcase
    end
endmodule

// File: rtl/win_beat_sel.sv
module win_beat_sel
    import wcs_pkg::*;
(
    input  job_t              job,
    input  logic [STEP_W-1:0] step,
    output beat_t             beat
);
    always_comb begin
        case (step)
            4'd0:    beat = '{is_cmd: 1'b1, data: ADR_INMODE};
            4'd1:    beat = '{is_cmd: 1'b0, data: job.conv};
            4'd2:    beat = '{is_cmd: 1'b1, data: ADR_TRANSL};
            4'd3:    beat = '{is_cmd: 1'b0, data: job.transl};
            4'd4:    beat = '{is_cmd: 1'b1, data: ADR_WTYPE};
            4'd5:    beat = '{is_cmd: 1'b0, data: job.wtype};
            4'd6:    beat = '{is_cmd: 1'b1, data: ADR_WINDOW};
            4'd7:    beat = '{is_cmd: 1'b0, data: job.xs[7:0]};
            4'd8:    beat = '{is_cmd: 1'b0, data: job.xs[15:8]};
            4'd9:    beat = '{is_cmd: 1'b0, data: job.ys[7:0]};
            4'd10:   beat = '{is_cmd: 1'b0, data: job.ys[15:8]};
            4'd11:   beat = '{is_cmd: 1'b0, data: job.xe[7:0]};
            4'd12:   beat = '{is_cmd: 1'b0, data: job.xe[15:8]};
            4'd13:   beat = '{is_cmd: 1'b0, data: job.ye[7:0]};
            4'd14:   beat = '{is_cmd: 1'b0, data: job.ye[15:8]};
            default: beat = '{is_cmd: 1'b0, data: '0};
        endcase
    end
endmodule

// File: rtl/win_cmd_seq.sv
module win_cmd_seq
    import wcs_pkg::*;
#(
    parameter logic [7:0] WT_INIT = 8'hA4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [COORD_W-1:0] req_x,
    input  logic [COORD_W-1:0] req_y,
    input  logic [COORD_W-1:0] req_w,
    input  logic [COORD_W-1:0] req_h,
    input  logic [1:0]         req_mode,
    input  logic [FLAG_W-1:0]  req_flags,
    output logic               bus_valid,
    input  logic               bus_ready,
    output logic               bus_is_cmd,
    output logic [BYTE_W-1:0]  bus_data,
    output logic               xfer_start,
    output logic               err,
    output logic [BPP_W-1:0]   bpp
);
    typedef enum logic {S_IDLE, S_BUSY} state_e;

    state_e              state;
    logic [STEP_W-1:0]   step;
    job_t                job;
    fmt_t                fmt;
    beat_t               beat;
    logic                fmt_seen;
    cmode_e              prev_mode;
    logic [FLAG_W-1:0]   prev_flags;
    logic                accept;
    logic                new_fmt;
    logic                done_q;
    logic                err_q;
    logic [BPP_W-1:0]    bpp_q;

    win_fmt_decode u_fmt (
        .mode (cmode_e'(req_mode)),
        .fmt  (fmt)
    );

    win_beat_sel u_beat (
        .job  (job),
        .step (step),
        .beat (beat)
    );

    assign req_ready = (state == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign new_fmt   = !fmt_seen || (cmode_e'(req_mode) != prev_mode) || (req_flags != prev_flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            step       <= '0;
            job        <= '0;
            fmt_seen   <= 1'b0;
            prev_mode  <= CM_RGB565;
            prev_flags <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            bpp_q      <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (accept) begin
                if (!fmt.ok) begin
                    err_q <= 1'b1;
                end else begin
                    state      <= S_BUSY;
                    step       <= new_fmt ? '0 : WIN_STEP;
                    job.xs     <= req_x;
                    job.ys     <= req_y;
                    job.xe     <= last_coord(req_x, req_w);
                    job.ye     <= last_coord(req_y, req_h);
                    job.conv   <= fmt.conv;
                    job.transl <= fmt.transl;
                    job.wtype  <= {WT_INIT[7:2], 1'b0, req_flags[0]};
                    bpp_q      <= fmt.bpp;
                    fmt_seen   <= 1'b1;
                    prev_mode  <= cmode_e'(req_mode);
                    prev_flags <= req_flags;
                end
            end else if (state == S_BUSY && bus_ready) begin
                if (step == LAST_STEP) begin
                    state  <= S_IDLE;
                    done_q <= 1'b1;
                end else begin
                    step <= step + STEP_W'(1);
                end
            end
        end
    end

    assign bus_valid  = (state == S_BUSY);
    assign bus_is_cmd = beat.is_cmd;
    assign bus_data   = beat.data;
    assign xfer_start = done_q;
    assign err        = err_q;
    assign bpp        = bpp_q;

    // R9
    hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_data) && $stable(bus_is_cmd));

    // R8
    start_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_mode != 2'd3 |=> bus_valid && !req_ready);

    // R1
    first_beat_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_valid) |-> bus_is_cmd);

    // R10
    done_after_data_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> $past(bus_valid && bus_ready && !bus_is_cmd));

    // R5
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !bus_valid && !xfer_start);

    // R5
    err_after_bad_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_mode == 2'd3 |=> err && req_ready);

endmodule

// File: tb/test_win_cmd_seq.sv
module test_win_cmd_seq;
    localparam logic [7:0] WT = 8'hA4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_x = '0, req_y = '0, req_w = '0, req_h = '0;
    logic [1:0]  req_mode = '0;
    logic [2:0]  req_flags = '0;
    logic        bus_valid, bus_ready = 1'b0, bus_is_cmd;
    logic [7:0]  bus_data;
    logic        xfer_start, err;
    logic [4:0]  bpp;

    always #10 clk = ~clk;

    win_cmd_seq #(.WT_INIT(WT)) i_win_cmd_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_x(req_x), .req_y(req_y), .req_w(req_w), .req_h(req_h),
        .req_mode(req_mode), .req_flags(req_flags), .bus_valid(bus_valid),
        .bus_ready(bus_ready), .bus_is_cmd(bus_is_cmd), .bus_data(bus_data),
        .xfer_start(xfer_start), .err(err), .bpp(bpp)
    );

    int checks = 0;
    int errors = 0;

    int q_x[$], q_y[$], q_w[$], q_h[$], q_m[$], q_f[$], q_early[$];
    int   e_byte[$];
    bit   e_cmd[$];
    string e_tag[$];

    bit   m_seen = 0;
    int   m_mode = 0, m_flags = 0;
    bit   exp_done = 0, exp_err = 0, chk_bpp = 0;
    int   exp_bpp = 0;
    bit   stall_prev = 0;
    logic [7:0] prev_byte = '0;
    logic prev_cmd = 1'b0;
    logic [7:0] lfsr = 8'h5B;
    bit   always_rdy = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic add_req(input int x, y, w, h, m, f, early);
        q_x.push_back(x); q_y.push_back(y); q_w.push_back(w); q_h.push_back(h);
        q_m.push_back(m); q_f.push_back(f); q_early.push_back(early);
    endtask

    task automatic push_beat(input int b, input bit c, input string t);
        e_byte.push_back(b & 8'hFF); e_cmd.push_back(c); e_tag.push_back(t);
    endtask

    task automatic model_accept(input int x, y, w, h, m, f);
        int conv, tr, xe, ye;
        if (m == 3) begin
            exp_err = 1; // R5: no beats, remembered format kept
            return;
        end
        case (m)
            0: begin conv = 8'h01; tr = 8'h05; exp_bpp = 16; end
            1: begin conv = 8'h08; tr = 8'h25; exp_bpp = 16; end
            default: begin conv = 8'h09; tr = 8'h25; exp_bpp = 12; end
        endcase
        chk_bpp = 1;
        if (!m_seen || m != m_mode || f != m_flags) begin
            push_beat(8'h2A, 1, "R1 inmode cmd");
            push_beat(conv, 0, "R4 inmode data");
            push_beat(8'h2E, 1, "R1 transl cmd");
            push_beat(tr, 0, "R4 transl data");
            push_beat(8'h36, 1, "R6 wtype cmd");
            push_beat({WT[7:2], 1'b0, f[0]}, 0, "R7 wtype data");
        end
        m_seen = 1; m_mode = m; m_flags = f;
        xe = (x + w - 1) & 16'hFFFF;
        ye = (y + h - 1) & 16'hFFFF;
        push_beat(8'h38, 1, "R2 window cmd");
        push_beat(x, 0, "R2 xs lo");
        push_beat(x >> 8, 0, "R2 xs hi");
        push_beat(y, 0, "R2 ys lo");
        push_beat(y >> 8, 0, "R2 ys hi");
        push_beat(xe, 0, "R3 xe lo");
        push_beat(xe >> 8, 0, "R3 xe hi");
        push_beat(ye, 0, "R3 ye lo");
        push_beat(ye >> 8, 0, "R3 ye hi");
    endtask

    initial begin
        add_req(100, 50, 20, 10, 0, 0, 0);
        add_req(3, 7, 1, 1, 0, 0, 1);
        add_req(0, 0, 16'h10, 16'h20, 1, 1, 0);
        add_req(16'h1234, 16'h00FF, 16'h100, 2, 2, 1, 1);
        add_req(5, 5, 5, 5, 3, 1, 0);
        add_req(16'h1234, 16'h00FF, 4, 4, 2, 1, 0);
        add_req(8, 9, 10, 11, 2, 4, 1);
        add_req(16'hFFFF, 0, 2, 1, 0, 4, 1);
        add_req(16'h0200, 16'h0300, 16'h0E00, 16'h0D01, 0, 4, 1);

        repeat (3) @(negedge clk);
        // R8 reset state
        check(req_ready === 1'b1, "R8 reset ready", int'(req_ready), 1);
        check(bus_valid === 1'b0, "R8 reset bus_valid", int'(bus_valid), 0);
        check(xfer_start === 1'b0 && err === 1'b0, "R10 reset pulses", int'(xfer_start), 0);
        rst = 1'b0;

        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(negedge clk);
            check(req_ready === (e_byte.size() == 0), "R8 ready", int'(req_ready), int'(e_byte.size() == 0));
            check(bus_valid === (e_byte.size() != 0), "R8 bus_valid", int'(bus_valid), int'(e_byte.size() != 0));
            check(xfer_start === exp_done, "R10 xfer_start", int'(xfer_start), int'(exp_done));
            check(err === exp_err, "R5 err", int'(err), int'(exp_err));
            if (chk_bpp) check(bpp === 5'(exp_bpp), "R11 bpp", int'(bpp), exp_bpp);
            if (stall_prev && bus_valid)
                check(bus_data === prev_byte && bus_is_cmd === prev_cmd, "R9 hold", int'(bus_data), int'(prev_byte));
            exp_done = 0; exp_err = 0; chk_bpp = 0;

            if (q_x.size() == 0 && e_byte.size() == 0 && !xfer_start && !err) begin
                break;
            end

            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            always_rdy = (q_x.size() <= 3);
            bus_ready = always_rdy ? 1'b1 : (lfsr[1:0] != 2'b00);

            if (bus_valid && bus_ready) begin
                check(int'(bus_data) == e_byte[0] && bus_is_cmd == e_cmd[0], e_tag[0],
                      int'({bus_is_cmd, bus_data}), int'({e_cmd[0], e_byte[0][7:0]}));
                void'(e_byte.pop_front()); void'(e_cmd.pop_front()); void'(e_tag.pop_front());
                if (e_byte.size() == 0) exp_done = 1;
            end
            stall_prev = bus_valid && !bus_ready;
            prev_byte  = bus_data;
            prev_cmd   = bus_is_cmd;

            if (q_x.size() != 0 && (req_ready || q_early[0] != 0)) begin
                req_valid = 1'b1;
                req_x = 16'(q_x[0]); req_y = 16'(q_y[0]);
                req_w = 16'(q_w[0]); req_h = 16'(q_h[0]);
                req_mode = 2'(q_m[0]); req_flags = 3'(q_f[0]);
            end else begin
                req_valid = 1'b0;
            end
            if (req_valid && req_ready) begin
                model_accept(q_x[0], q_y[0], q_w[0], q_h[0], q_m[0], q_f[0]);
                void'(q_x.pop_front()); void'(q_y.pop_front()); void'(q_w.pop_front());
                void'(q_h.pop_front()); void'(q_m.pop_front()); void'(q_f.pop_front());
                void'(q_early.pop_front());
            end
            if (cyc == 19999) begin
                errors++;
                $display("FAIL watchdog R8 actual=%0d expected=%0d", q_x.size(), 0);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule